// File: doc/BRIEF.md
# ASID-qualified address watchpoint

This block is one hardware watchpoint for a processor core. Software programs two 32-bit registers through a small register port. The base register holds a watched address together with three enable bits, one each for instruction fetch, load and store. The qualifier register holds a global flag, an address-space identifier and a nine-bit address mask.

For every valid access, the unit compares three things against the programmed values: the virtual address, the access kind and the current address-space identifier. On a match it raises a watch-exception request for exactly one cycle. Comparison always ignores address bits 2:0, so the unit watches doublewords. Each set mask bit turns one of address bits 11:3 into a don't-care. A set global flag makes the identifier irrelevant. While the core runs in debug mode, no request is raised.

Top module: `addr_watch_unit`

## Requirements
- R1: After a synchronous reset, `watch_req` is 0 and both registers read back as zero.
- R2: A write with `reg_sel`=0 stores all 32 bits of `reg_wdata` in the base register. Layout: bits 31:3 hold the address, bit 2 enables fetch, bit 1 enables load, bit 0 enables store.
- R3: A write with `reg_sel`=1 keeps only the global flag (bit 30), the identifier (bits 23:16) and the mask (bits 11:3). All other bits of the qualifier register always read as 0.
- R4: Address bits 31:3 of the access must equal the base address, and bits 2:0 never affect the result.
- R5: A qualifier mask bit at position k (3..11) set to 1 excludes address bit k from the compare.
- R6: With the global flag at 0, a match also needs `cur_asid` to equal the stored identifier. With the flag at 1, `cur_asid` is ignored.
- R7: `acc_type` encodes 0 = fetch, 1 = load, 2 = store and 3 = no access. A match counts only if the enable bit for that kind is set. Kind 3, or all enables at 0, never matches.
- R8: `watch_req` is 1 in the cycle after each matching cycle with `acc_valid`=1, and 0 after every other cycle. Consecutive matching strobes give consecutive pulses.
- R9: An access presented while `debug_mode`=1 never raises `watch_req`.
- R10: `reg_rdata` shows, one cycle later, the register chosen by `reg_sel` as it stood before any write in that same cycle. An access in the same cycle as a register write is judged against the pre-write contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = base register, 1 = qualifier register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for `reg_sel` |
| acc_valid | input | 1 | Access strobe |
| acc_type | input | 2 | Access kind (0 fetch, 1 load, 2 store, 3 none) |
| acc_addr | input | 32 | Virtual address of the access |
| cur_asid | input | 8 | Current address-space identifier |
| debug_mode | input | 1 | Core is in debug mode |
| watch_req | output | 1 | One-cycle watch-exception request |

## Verification
A register write and an access that the written value would decide can land on the same clock edge. Whether that access fires must follow the old register contents. The bench provokes this by writing a new base address while presenting an access that matches only the old one, and then the reverse. The behavioural model updates its copy only after it has computed that cycle's expected request, and the request and read data are compared on every clock.

// File: rtl/watch_pkg.sv
package watch_pkg;
  localparam int WP_DATA_W   = 32;
  localparam int WP_ASID_W   = 8;
  localparam int WP_MASK_W   = 9;
  localparam int WP_LOW_W    = 3;
  localparam int WP_ASID_LSB = 16;
  localparam int WP_GLOB_BIT = 30;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam int EN_FETCH = 2;
  localparam int EN_LOAD  = 1;
  localparam int EN_STORE = 0;
endpackage

// File: rtl/watch_regs.sv
module watch_regs #(
  parameter int DATA_W   = 32,
  parameter int ASID_W   = 8,
  parameter int MASK_W   = 9,
  parameter int LOW_W    = 3,
  parameter int ASID_LSB = 16,
  parameter int GLOB_BIT = 30
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic                    reg_sel,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic [DATA_W-1:LOW_W]   base_addr,
  output logic [LOW_W-1:0]        kind_en,
  output logic                    glob,
  output logic [ASID_W-1:0]       asid,
  output logic [MASK_W-1:0]       mask
);
  localparam int MASK_LSB = LOW_W;
  localparam int MASK_MSB = LOW_W + MASK_W - 1;
  localparam int ASID_MSB = ASID_LSB + ASID_W - 1;

  logic [DATA_W-1:0] base_word;
  logic [DATA_W-1:0] qual_word;

  assign base_word = {base_addr, kind_en};

  always_comb begin
    qual_word = '0;
    qual_word[GLOB_BIT] = glob;
    qual_word[ASID_MSB:ASID_LSB] = asid;
    qual_word[MASK_MSB:MASK_LSB] = mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      kind_en   <= '0;
      glob      <= 1'b0;
      asid      <= '0;
      mask      <= '0;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= reg_sel ? qual_word : base_word;
      if (reg_we && !reg_sel) begin
        base_addr <= reg_wdata[DATA_W-1:LOW_W];
        kind_en   <= reg_wdata[LOW_W-1:0];
      end
      if (reg_we && reg_sel) begin
        glob <= reg_wdata[GLOB_BIT];
        asid <= reg_wdata[ASID_MSB:ASID_LSB];
        mask <= reg_wdata[MASK_MSB:MASK_LSB];
      end
    end
  end
endmodule

// File: rtl/watch_match.sv
module watch_match
  import watch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int MASK_W = 9,
  parameter int LOW_W  = 3
) (
  input  logic [DATA_W-1:LOW_W] base_addr,
  input  logic [LOW_W-1:0]      kind_en,
  input  logic                  glob,
  input  logic [ASID_W-1:0]     asid,
  input  logic [MASK_W-1:0]     mask,
  input  logic [DATA_W-1:0]     acc_addr,
  input  logic [1:0]            acc_type,
  input  logic [ASID_W-1:0]     cur_asid,
  output logic                  hit
);
  logic [DATA_W-1:LOW_W] bit_ok;
  logic kind_ok;
  logic asid_ok;

  for (genvar i = LOW_W; i < DATA_W; i++) begin : g_bit
    if (i < LOW_W + MASK_W) begin : g_masked
      assign bit_ok[i] = (acc_addr[i] == base_addr[i]) | mask[i-LOW_W];
    end else begin : g_exact
      assign bit_ok[i] = (acc_addr[i] == base_addr[i]);
    end
  end

  always_comb begin
    unique case (acc_kind_e'(acc_type))
      ACC_FETCH: kind_ok = kind_en[EN_FETCH];
      ACC_LOAD:  kind_ok = kind_en[EN_LOAD];
      ACC_STORE: kind_ok = kind_en[EN_STORE];
      default:   kind_ok = 1'b0;
    endcase
  end

  assign asid_ok = glob | (asid == cur_asid);
  assign hit     = (&bit_ok) & kind_ok & asid_ok;
endmodule

// File: rtl/watch_req_gen.sv
module watch_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic acc_valid,
  input  logic hit,
  input  logic debug_mode,
  output logic watch_req
);
  always_ff @(posedge clk) begin
    if (rst) watch_req <= 1'b0;
    else     watch_req <= acc_valid & hit & ~debug_mode;
  end
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import watch_pkg::*;
#(
  parameter int DATA_W   = WP_DATA_W,
  parameter int ASID_W   = WP_ASID_W,
  parameter int MASK_W   = WP_MASK_W,
  parameter int LOW_W    = WP_LOW_W,
  parameter int ASID_LSB = WP_ASID_LSB,
  parameter int GLOB_BIT = WP_GLOB_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_type,
  input  logic [DATA_W-1:0] acc_addr,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              debug_mode,
  output logic              watch_req
);
  logic [DATA_W-1:LOW_W] base_addr;
  logic [LOW_W-1:0]      kind_en;
  logic                  glob;
  logic [ASID_W-1:0]     asid;
  logic [MASK_W-1:0]     mask;
  logic                  hit;

  watch_regs #(
    .DATA_W(DATA_W), .ASID_W(ASID_W), .MASK_W(MASK_W),
    .LOW_W(LOW_W), .ASID_LSB(ASID_LSB), .GLOB_BIT(GLOB_BIT)
  ) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .base_addr(base_addr), .kind_en(kind_en), .glob(glob),
    .asid(asid), .mask(mask)
  );

  watch_match #(
    .DATA_W(DATA_W), .ASID_W(ASID_W), .MASK_W(MASK_W), .LOW_W(LOW_W)
  ) match_i (
    .base_addr(base_addr), .kind_en(kind_en), .glob(glob), .asid(asid),
    .mask(mask), .acc_addr(acc_addr), .acc_type(acc_type),
    .cur_asid(cur_asid), .hit(hit)
  );

  watch_req_gen req_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .hit(hit),
    .debug_mode(debug_mode), .watch_req(watch_req)
  );
endmodule

// File: rtl/watch_unit_chk.sv
module watch_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              acc_valid,
  input logic [1:0]        acc_type,
  input logic              debug_mode,
  input logic              watch_req
);
  a_r8_no_req_without_access: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !watch_req);

  a_r9_debug_silent: assert property (@(posedge clk) disable iff (rst)
    debug_mode |=> !watch_req);

  a_r7_kind_none_silent: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_type == 2'd3) |=> !watch_req);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_sel |=> (reg_rdata[31] == 1'b0 && reg_rdata[29:24] == 6'd0 &&
                 reg_rdata[15:12] == 4'd0 && reg_rdata[2:0] == 3'd0));

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!watch_req && reg_rdata == '0));
endmodule

bind addr_watch_unit watch_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .acc_valid(acc_valid), .acc_type(acc_type), .debug_mode(debug_mode),
  .watch_req(watch_req)
);

// File: tb/addr_watch_unit_tb_top.sv
`timescale 1ns/1ps
module addr_watch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_type = 2'd3;
  logic [31:0] acc_addr = '0;
  logic [7:0]  cur_asid = '0;
  logic        debug_mode = 1'b0;
  logic        watch_req;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    edge_seen = 0;
  string phase = "R1";

  logic [31:0] m_base = '0;
  logic [31:0] m_qual = '0;
  logic        exp_req = 1'b0;
  logic [31:0] exp_rdata = '0;

  always #2.5 clk = ~clk;

  addr_watch_unit dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_type(acc_type), .acc_addr(acc_addr), .cur_asid(cur_asid),
    .debug_mode(debug_mode), .watch_req(watch_req)
  );

  function automatic bit ref_hit(logic [31:0] a, logic [1:0] t, logic [7:0] s);
    if (t == 2'd3) return 0;
    if (!m_base[2 - int'(t)]) return 0;
    if (!m_qual[30] && m_qual[23:16] != s) return 0;
    for (int b = 3; b < 32; b++) begin
      if (b < 12 && m_qual[b]) continue;
      if (a[b] != m_base[b]) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    edge_seen <= 1'b1;
    if (rst) begin
      m_base = '0; m_qual = '0; exp_req = 1'b0; exp_rdata = '0;
    end else begin
      exp_req   = acc_valid && !debug_mode && ref_hit(acc_addr, acc_type, cur_asid);
      exp_rdata = reg_sel ? m_qual : m_base;
      if (reg_we) begin
        if (reg_sel) m_qual = reg_wdata & 32'h40FF_0FF8;
        else         m_base = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (edge_seen) begin
      n_checks++;
      if (watch_req !== exp_req) begin
        n_fail++;
        $display("FAIL %s watch_req actual %0b expected %0b", phase, watch_req, exp_req);
      end
      n_checks++;
      if (reg_rdata !== exp_rdata) begin
        n_fail++;
        $display("FAIL %s reg_rdata actual %h expected %h", phase, reg_rdata, exp_rdata);
      end
    end
  end

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic acc(input logic [1:0] t, input logic [31:0] a, input logic [7:0] s);
    @(negedge clk);
    acc_valid = 1'b1; acc_type = t; acc_addr = a; cur_asid = s;
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic look(input logic sel);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    look(1'b0); look(1'b1);

    phase = "R2";
    wr(1'b0, 32'h1234_5677); look(1'b0);
    phase = "R3";
    wr(1'b1, 32'hFFFF_FFFF); look(1'b1);
    wr(1'b1, 32'hA5A5_5A5A); look(1'b1);

    phase = "R4";
    wr(1'b0, 32'h0000_1007);
    wr(1'b1, 32'h4000_0000);
    for (int k = 0; k < 8; k++) acc(2'd1, 32'h0000_1000 + k, 8'h00);
    acc(2'd1, 32'h0000_1008, 8'h00);
    acc(2'd1, 32'h8000_1000, 8'h00);

    phase = "R5";
    wr(1'b1, 32'h4000_0FF8);
    acc(2'd2, 32'h0000_1FF8, 8'h00);
    acc(2'd2, 32'h0000_3000, 8'h00);
    wr(1'b1, 32'h4000_0010);
    acc(2'd2, 32'h0000_1010, 8'h00);
    acc(2'd2, 32'h0000_1008, 8'h00);

    phase = "R6";
    wr(1'b1, 32'h005A_0000);
    acc(2'd0, 32'h0000_1000, 8'h5A);
    acc(2'd0, 32'h0000_1000, 8'h5B);
    wr(1'b1, 32'h405A_0000);
    acc(2'd0, 32'h0000_1000, 8'h5B);

    phase = "R7";
    wr(1'b0, 32'h0000_1004);
    acc(2'd0, 32'h0000_1000, 8'h00);
    acc(2'd1, 32'h0000_1000, 8'h00);
    acc(2'd2, 32'h0000_1000, 8'h00);
    acc(2'd3, 32'h0000_1000, 8'h00);
    wr(1'b0, 32'h0000_1000);
    for (int t = 0; t < 4; t++) acc(2'(t), 32'h0000_1000, 8'h00);

    phase = "R8";
    wr(1'b0, 32'h0000_1007);
    @(negedge clk);
    acc_valid = 1'b1; acc_type = 2'd1; acc_addr = 32'h0000_1000;
    repeat (4) @(negedge clk);
    acc_addr = 32'h0000_2000;
    @(negedge clk);
    acc_addr = 32'h0000_1000;
    @(negedge clk);
    acc_valid = 1'b0;
    repeat (2) @(negedge clk);

    phase = "R9";
    debug_mode = 1'b1;
    acc(2'd1, 32'h0000_1000, 8'h00);
    debug_mode = 1'b0;
    acc(2'd1, 32'h0000_1000, 8'h00);

    phase = "R10";
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_5007;
    acc_valid = 1'b1; acc_type = 2'd1; acc_addr = 32'h0000_1000;
    @(negedge clk);
    reg_we = 1'b0;
    acc_addr = 32'h0000_5000;
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = 32'h0000_1007;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h4000_0000;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (2) @(negedge clk);

    phase = "R4";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      reg_we = ($urandom_range(0, 15) == 0);
      reg_sel = 1'($urandom_range(0, 1));
      reg_wdata = reg_sel ? ($urandom & 32'h40FF_0FF8) | 32'h0000_0E00
                          : {20'h00001, 12'($urandom)};
      acc_valid = 1'($urandom_range(0, 1));
      acc_type = 2'($urandom_range(0, 3));
      acc_addr = {20'h00001, 12'($urandom)};
      cur_asid = 8'($urandom_range(0, 3));
      debug_mode = ($urandom_range(0, 9) == 0);
    end
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0; debug_mode = 1'b0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule